// File: doc/BRIEF.md
# Source-Synchronous Link Transmit Serializer

This block sits between a wide core-side datapath and a narrow chip-to-chip data bus. The core offers a packet word with a valid strobe; the block pushes back with a wait signal whenever it cannot take the word. An accepted word is held in a register and cut into lane-wide flits. The flits leave on the link together with a framing signal and a clock-enable. The pad layer uses that clock-enable to drive the forwarded clock, shifted a quarter period so that its edge falls in the middle of each data eye.

Each packet captures its own settings when it is accepted: the flit count (an 8-bit field), the flit order, and single or double data rate. The flit order is either lowest slice first or highest slice first. In double-rate mode the link is modelled as two lanes, one for the rising half-period and one for the falling half-period, and both are refreshed on every clock. A far-end wait input freezes the link output. A disable bit stops new packets from entering but lets the packet in progress finish. Packets follow one another with no idle cycle when the core keeps a word ready.

Top module: `link_tx_serializer`

## Requirements
- R1: While reset is asserted, and after it is released with no word accepted, link_frame, link_clk_en, link_rise and link_fall are all zero.
- R2: A word is taken on a rising edge where core_valid is high and core_wait is low. Its first flit is driven on the following rising edge. core_wait is low whenever the block is enabled and holds no packet, whatever the state of link_wait.
- R3: With the order bit clear, flit k of a packet is core_data[k*LANE_W +: LANE_W], so flit 0 is the least significant slice.
- R4: With the order bit set, flit k of an F-flit packet is slice F-1-k, so the highest slice of the payload leaves first.
- R5: The flit count F is cfg_flits, with 0 treated as 1 and values above PKT_W/LANE_W limited to PKT_W/LANE_W. F, the order bit and the rate bit are captured when the word is accepted and are not affected by later changes.
- R6: In single-rate mode, one flit leaves per cycle on link_rise, link_fall stays zero, and a packet occupies F cycles.
- R7: In double-rate mode, each cycle carries flit k on link_rise and flit k+1 on link_fall, with k even. A packet occupies ceil(F/2) cycles. When F is odd, link_fall is zero in the last cycle.
- R8: link_frame is high in every cycle whose lanes carry packet flits and low when the link is idle. link_clk_en is high only together with link_frame, and only in a cycle that carries freshly issued flits.
- R9: When the last flit step of a packet is issued and core_valid is high, the next word is taken on that same edge. link_frame then stays high with no gap between the two packets.
- R10: On an edge where link_wait is high, link_frame, link_rise and link_fall keep their values, link_clk_en goes low, the flit position does not advance, and a word is accepted only if no packet is held.
- R11: While cfg_tx_off is high, core_wait is high and no word is accepted. A packet already held still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_tx_off | input | 1 | Disables acceptance of new packets |
| cfg_ddr | input | 1 | Double data rate select |
| cfg_msb_first | input | 1 | Highest slice first when set |
| cfg_flits | input | 8 | Flits per packet |
| core_valid | input | 1 | Core word valid |
| core_data | input | PKT_W | Core packet word |
| core_wait | output | 1 | Pushback toward the core |
| link_wait | input | 1 | Pushback from the far-end receiver |
| link_frame | output | 1 | Packet framing on the link |
| link_clk_en | output | 1 | Enable for the forwarded clock in this cycle |
| link_rise | output | LANE_W | Flit for the rising half-period |
| link_fall | output | LANE_W | Flit for the falling half-period (double rate) |

## Verification
The hardest case to reach from the ports is a far-end wait that arrives in the very cycle that would issue a packet's last flit step, while the core is already offering the next word. Acceptance must then be deferred and the framing must not drop. The stimulus gets there by holding core_valid high in long runs while link_wait toggles pseudo-randomly, across odd and even flit counts in both rates. Because packet lengths and stall positions vary, the last step of a packet meets a stall many times. A cycle-by-cycle reference model judges every output on every clock, including runs where the settings change in the middle of a packet.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;

   // Effective flit count: zero means one, and the count is limited to the slices available
   function automatic int unsigned flits_eff(input logic [7:0] raw, input int unsigned lim);
      if (raw == 8'd0)
         return 1;
      else if (int'(raw) > int'(lim))
         return lim;
      else
         return int'(raw);
   endfunction

endpackage

// File: rtl/link_tx_flit_ctr.sv
module link_tx_flit_ctr #(
   parameter int SLICES = 8,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_f,
   input  logic             load_ddr,
   input  logic             link_wait,
   output logic             busy,
   output logic             ddr,
   output logic [CNT_W-1:0] idx,
   output logic [CNT_W-1:0] flits,
   output logic             issue,
   output logic             last
);

   logic [CNT_W-1:0] step;
   logic [CNT_W-1:0] rem;

   assign step  = ddr ? CNT_W'(2) : CNT_W'(1);
   assign rem   = flits - idx;
   assign issue = busy && !link_wait;
   assign last  = issue && (rem <= step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         ddr   <= 1'b0;
         idx   <= '0;
         flits <= CNT_W'(1);
      end else if (load) begin
         busy  <= 1'b1;
         ddr   <= load_ddr;
         idx   <= '0;
         flits <= load_f;
      end else if (last) begin
         busy <= 1'b0;
         idx  <= '0;
      end else if (issue) begin
         idx <= idx + step;
      end
   end

   // R5
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx < flits) && (flits <= CNT_W'(SLICES)));

   // R2
   load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy && (idx == '0));

endmodule

// File: rtl/link_tx_slicer.sv
module link_tx_slicer #(
   parameter int PKT_W  = 64,
   parameter int LANE_W = 8,
   parameter int CNT_W  = 4
) (
   input  logic [PKT_W-1:0]  data,
   input  logic [CNT_W-1:0]  k,
   input  logic [CNT_W-1:0]  flits,
   input  logic              msb_first,
   input  logic              en,
   output logic [LANE_W-1:0] flit
);

   localparam int SLICES = PKT_W / LANE_W;

   logic              hit;
   logic [CNT_W-1:0]  sel;

   assign hit = en && (k < flits);
   assign sel = msb_first ? (flits - CNT_W'(1) - k) : k;

   generate
      if (SLICES == 1) begin : g_single
         assign flit = hit ? data : '0;
      end else begin : g_multi
         localparam int SEL_W = $clog2(SLICES);
         logic [LANE_W-1:0] part [SLICES];
         for (genvar s = 0; s < SLICES; s++) begin : g_part
            assign part[s] = data[s*LANE_W +: LANE_W];
         end
         assign flit = hit ? part[sel[SEL_W-1:0]] : '0;
      end
   endgenerate

endmodule

// File: rtl/link_tx_out_reg.sv
module link_tx_out_reg #(
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              advance,
   input  logic              busy,
   input  logic [LANE_W-1:0] rise_d,
   input  logic [LANE_W-1:0] fall_d,
   output logic              frame,
   output logic              clk_en,
   output logic [LANE_W-1:0] rise_q,
   output logic [LANE_W-1:0] fall_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame  <= 1'b0;
         clk_en <= 1'b0;
         rise_q <= '0;
         fall_q <= '0;
      end else if (advance) begin
         frame  <= busy;
         clk_en <= busy;
         rise_q <= rise_d;
         fall_q <= fall_d;
      end else begin
         clk_en <= 1'b0;
      end
   end

   // R8
   clken_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> frame);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !advance |=> $stable(frame) && $stable(rise_q) && $stable(fall_q) && !clk_en);

endmodule

// File: rtl/link_tx_serializer.sv
module link_tx_serializer #(
   parameter int PKT_W  = 64,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_tx_off,
   input  logic              cfg_ddr,
   input  logic              cfg_msb_first,
   input  logic [7:0]        cfg_flits,
   input  logic              core_valid,
   input  logic [PKT_W-1:0]  core_data,
   output logic              core_wait,
   input  logic              link_wait,
   output logic              link_frame,
   output logic              link_clk_en,
   output logic [LANE_W-1:0] link_rise,
   output logic [LANE_W-1:0] link_fall
);

   localparam int SLICES = PKT_W / LANE_W;
   localparam int CNT_W  = $clog2(SLICES + 2);

   generate
      if (LANE_W < 1 || PKT_W % LANE_W != 0) begin : g_bad_width
         $error("PKT_W must be a whole multiple of LANE_W");
      end
      if (SLICES > 255) begin : g_bad_count
         $error("PKT_W/LANE_W must not exceed the 8-bit flit count");
      end
   endgenerate

   logic              busy, ddr_q, issue, last;
   logic [CNT_W-1:0]  idx, flits, load_f;
   logic              accept_ok, load;
   logic [PKT_W-1:0]  pkt_q;
   logic              msb_q;
   logic [LANE_W-1:0] rise_d, fall_d;
   logic [CNT_W-1:0]  fall_k;

   assign accept_ok = !cfg_tx_off && (!busy || last);
   assign core_wait = !accept_ok;
   assign load      = core_valid && accept_ok;
   assign load_f    = CNT_W'(link_tx_pkg::flits_eff(cfg_flits, SLICES));
   assign fall_k    = idx + CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_q <= '0;
         msb_q <= 1'b0;
      end else if (load) begin
         pkt_q <= core_data;
         msb_q <= cfg_msb_first;
      end
   end

   link_tx_flit_ctr #(.SLICES(SLICES), .CNT_W(CNT_W)) i_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_f    (load_f),
      .load_ddr  (cfg_ddr),
      .link_wait (link_wait),
      .busy      (busy),
      .ddr       (ddr_q),
      .idx       (idx),
      .flits     (flits),
      .issue     (issue),
      .last      (last)
   );

   link_tx_slicer #(.PKT_W(PKT_W), .LANE_W(LANE_W), .CNT_W(CNT_W)) i_rise (
      .data      (pkt_q),
      .k         (idx),
      .flits     (flits),
      .msb_first (msb_q),
      .en        (busy),
      .flit      (rise_d)
   );

   link_tx_slicer #(.PKT_W(PKT_W), .LANE_W(LANE_W), .CNT_W(CNT_W)) i_fall (
      .data      (pkt_q),
      .k         (fall_k),
      .flits     (flits),
      .msb_first (msb_q),
      .en        (busy && ddr_q),
      .flit      (fall_d)
   );

   link_tx_out_reg #(.LANE_W(LANE_W)) i_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (!link_wait),
      .busy    (busy),
      .rise_d  (rise_d),
      .fall_d  (fall_d),
      .frame   (link_frame),
      .clk_en  (link_clk_en),
      .rise_q  (link_rise),
      .fall_q  (link_fall)
   );

   // R11
   off_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_tx_off |-> core_wait);

   // R9
   gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last && core_valid && !cfg_tx_off) |=> busy && issue |=> link_frame);

   // R6
   sdr_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && !ddr_q) |=> (link_fall == '0));

endmodule

// File: tb/test_link_tx_serializer.sv
module test_link_tx_serializer;

   localparam int PERIOD = 10;
   localparam int PW     = 64;
   localparam int NW     = 8;
   localparam int NSL    = PW / NW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_tx_off = 1'b0, cfg_ddr = 1'b0, cfg_msb_first = 1'b0;
   logic [7:0]    cfg_flits = 8'd8;
   logic          core_valid = 1'b0;
   logic [PW-1:0] core_data = '0;
   logic          core_wait;
   logic          link_wait = 1'b0;
   logic          link_frame, link_clk_en;
   logic [NW-1:0] link_rise, link_fall;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   link_tx_serializer #(.PKT_W(PW), .LANE_W(NW)) i_link_tx_serializer (
      .clk(clk), .rst_n(rst_n), .cfg_tx_off(cfg_tx_off), .cfg_ddr(cfg_ddr),
      .cfg_msb_first(cfg_msb_first), .cfg_flits(cfg_flits), .core_valid(core_valid),
      .core_data(core_data), .core_wait(core_wait), .link_wait(link_wait),
      .link_frame(link_frame), .link_clk_en(link_clk_en),
      .link_rise(link_rise), .link_fall(link_fall));

   // Reference model state
   logic [PW-1:0] m_pkt;
   int            m_f, m_idx;
   bit            m_busy, m_ddr, m_msb;
   bit            e_frame, e_ce;
   logic [NW-1:0] e_rise, e_fall;

   function automatic int eff(input logic [7:0] raw);
      if (raw == 0) return 1;
      if (int'(raw) > NSL) return NSL;
      return int'(raw);
   endfunction

   function automatic logic [NW-1:0] flit_of(input int k);
      int s;
      if (k >= m_f) return '0;
      s = m_msb ? (m_f - 1 - k) : k;
      return NW'(m_pkt >> (s * NW));
   endfunction

   function automatic bit m_last_now();
      int step;
      step = m_ddr ? 2 : 1;
      return m_busy && !link_wait && ((m_f - m_idx) <= step);
   endfunction

   function automatic bit m_wait();
      return cfg_tx_off || (m_busy && !m_last_now());
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_idx = 0; m_f = 1; m_ddr = 0; m_msb = 0; m_pkt = '0;
         e_frame = 0; e_ce = 0; e_rise = '0; e_fall = '0;
      end else begin
         bit acc, lst;
         acc = core_valid && !m_wait();
         lst = m_last_now();
         if (!link_wait) begin
            e_frame = m_busy;
            e_ce    = m_busy;
            e_rise  = m_busy ? flit_of(m_idx) : '0;
            e_fall  = (m_busy && m_ddr) ? flit_of(m_idx + 1) : '0;
            if (m_busy) begin
               if (lst) begin m_busy = 0; m_idx = 0; end
               else m_idx = m_idx + (m_ddr ? 2 : 1);
            end
         end else begin
            e_ce = 0;
         end
         if (acc) begin
            m_pkt = core_data; m_f = eff(cfg_flits); m_ddr = cfg_ddr;
            m_msb = cfg_msb_first; m_busy = 1; m_idx = 0;
         end
      end
   end

   task automatic check(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Inputs are driven at the falling edge; outputs are compared before new inputs are applied
   task automatic run_phase(input string tag, input int n, input bit ddr, input bit msb,
                            input logic [7:0] fl, input int vpct, input int wpct, input bit off);
      for (int c = 0; c < n; c++) begin
         @(negedge clk);
         check("R8", "link_frame", link_frame, e_frame);
         check("R8", "link_clk_en", link_clk_en, e_ce);
         check(tag, "link_rise", link_rise, e_rise);
         check(tag, "link_fall", link_fall, e_fall);
         cfg_ddr       = ddr;
         cfg_msb_first = msb;
         cfg_flits     = fl;
         cfg_tx_off    = off;
         core_valid    = ($urandom_range(99) < vpct);
         core_data     = {$urandom(), $urandom()};
         link_wait     = ($urandom_range(99) < wpct);
         #1;
         check("R2", "core_wait", core_wait, m_wait());
      end
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5a17));
      repeat (3) @(negedge clk);
      // R1: outputs low during reset
      check("R1", "frame in reset", link_frame, 0);
      check("R1", "rise in reset", link_rise, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "frame after reset", link_frame, 0);
      check("R1", "clk_en after reset", link_clk_en, 0);
      check("R1", "fall after reset", link_fall, 0);
      check("R2", "idle wait low", core_wait, 0);

      run_phase("R3", 300, 0, 0, 8'd8, 40, 0, 0);
      run_phase("R6", 300, 0, 0, 8'd3, 60, 0, 0);
      run_phase("R4", 300, 0, 1, 8'd6, 50, 0, 0);
      run_phase("R7", 300, 1, 0, 8'd8, 50, 0, 0);
      run_phase("R7", 300, 1, 1, 8'd5, 70, 0, 0);
      run_phase("R7", 200, 1, 0, 8'd1, 70, 0, 0);
      run_phase("R5", 200, 0, 0, 8'd0, 60, 0, 0);
      run_phase("R5", 200, 1, 1, 8'd20, 60, 0, 0);
      run_phase("R9", 400, 0, 1, 8'd4, 100, 0, 0);
      run_phase("R9", 400, 1, 0, 8'd7, 100, 0, 0);
      run_phase("R10", 600, 0, 0, 8'd5, 100, 40, 0);
      run_phase("R10", 600, 1, 1, 8'd3, 90, 40, 0);
      run_phase("R3", 3, 0, 0, 8'd8, 100, 0, 0);
      run_phase("R11", 60, 0, 0, 8'd8, 100, 0, 1);
      run_phase("R11", 60, 1, 0, 8'd8, 100, 30, 1);
      // R5: settings change on every cycle while packets are in flight
      for (int r = 0; r < 400; r++)
         run_phase("R5", 1, r[0], r[1], 8'(r % 11), 80, 20, r % 37 == 0);
      run_phase("R10", 40, 0, 0, 8'd2, 0, 100, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule